// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block connects an internal request port to an external asynchronous memory bus. The internal side presents an address, write data, byte enables, a direction bit and a valid flag, and waits for a one-cycle acknowledge. The external bus serves three kinds of area. There are four SRAM banks, each with its own chip select and output enable. There is a PROM area split into two halves, each with its own chip select. There is one memory-mapped I/O area with its own select, read and write strobes, and an active-low ready input.

The controller decodes the area and the bank from the request address. It latches the access and then drives the active-low selects and strobes for as long as the access needs. SRAM and PROM accesses last a configured number of wait states. I/O accesses last until the device signals ready. The controller drives the data bus only on writes, and the checkbit lanes only on writes to protected areas. The checkbit values come from outside the block. The PROM and the I/O area can each be set to 8-bit width; such accesses use the top byte lane only. An address that decodes to no area completes with an error flag and causes no bus activity. Between accesses the external address bus keeps the address of the last real access.

Top module: `extmem_bus_ctrl`

## Requirements
- R1: Address decode uses req_addr[31:29]. 000 selects the PROM; req_addr[28]=0 asserts prom_cs_n[0] and req_addr[28]=1 asserts prom_cs_n[1]. 001 selects the I/O area. 010 with req_addr[28:23] all zero selects SRAM, with the bank given by req_addr[22:21]. In every cycle at most one select group (an SRAM bank, a PROM half or I/O) is low.
- R2: SRAM bank b drives sram_cs_n[b] low during its accesses, and drives sram_oe_n[b] low only during its reads.
- R3: On SRAM and PROM writes the strobes are active low and big-endian. wr_n[0] strobes bits 31:24 (req_be[3]), wr_n[1] strobes bits 23:16 (req_be[2]), wr_n[2] strobes bits 15:8 (req_be[1]) and wr_n[3] strobes bits 7:0 (req_be[0]). I/O accesses leave wr_n high.
- R4: mem_d_oe is high only in the strobe cycles of a write, and mem_d_out then carries the write data. On reads and when idle the bus is released.
- R5: When cfg_prom_narrow is set for the PROM, or cfg_io_narrow for I/O, the area is 8 bits wide. A write places req_wdata[7:0] on bits 31:24, strobed by wr_n[0] from req_be[0]. A read returns mem_d_in[31:24] zero-extended.
- R6: cb_oe is high only on writes to SRAM, or to a 32-bit PROM, while cfg_protect is set. cb_out then carries {cfg_test_bit, req_chk}.
- R7: An I/O read drives io_cs_n and io_oe_n low and io_rd high. An I/O write drives io_cs_n and io_wr_n low.
- R8: An I/O access keeps its strobes until io_ready_n is sampled low at a rising edge, holds them for one more cycle, and then completes. cfg_waits has no effect on I/O accesses.
- R9: SRAM and PROM strobes stay active for exactly cfg_waits+1 cycles.
- R10: ack is high for exactly one cycle, in the cycle right after the last strobe cycle. For reads, rdata is valid in that cycle.
- R11: All strobes and selects are inactive in the ack cycle, and at least one idle cycle separates back-to-back accesses.
- R12: An address outside every area gives ack with bus_err in the cycle after acceptance. No select or strobe is driven and mem_addr does not change.
- R13: mem_addr carries req_addr[22:0] of the last mapped access and holds it while the bus is idle.
- R14: After reset every select and strobe is inactive, mem_d_oe, cb_oe and ack are low, and mem_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit k covers data bits 8k+7:8k |
| req_chk | input | 7 | Checkbits supplied for the write |
| ack | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Unmapped address, valid with ack |
| rdata | output | 32 | Read data, valid with ack |
| cfg_waits | input | 4 | SRAM/PROM wait states |
| cfg_prom_narrow | input | 1 | PROM area is 8 bits wide |
| cfg_io_narrow | input | 1 | I/O area is 8 bits wide |
| cfg_protect | input | 1 | SRAM and 32-bit PROM carry checkbits |
| cfg_test_bit | input | 1 | Value for checkbit line 7 |
| mem_addr | output | 23 | External address |
| mem_d_out | output | 32 | External data, driven value |
| mem_d_oe | output | 1 | External data drive enable |
| mem_d_in | input | 32 | External data, sampled value |
| cb_out | output | 8 | Checkbit lines, driven value |
| cb_oe | output | 1 | Checkbit drive enable |
| sram_cs_n | output | 4 | SRAM bank selects, active low |
| sram_oe_n | output | 4 | SRAM bank output enables, active low |
| wr_n | output | 4 | Byte write strobes, active low |
| prom_cs_n | output | 2 | PROM half selects, active low |
| io_cs_n | output | 1 | I/O select, active low |
| io_oe_n | output | 1 | I/O output enable, active low |
| io_rd | output | 1 | I/O read indicator, active high |
| io_wr_n | output | 1 | I/O write strobe, active low |
| io_ready_n | input | 1 | I/O ready, active low |

## Verification
A request held at the accepting edge turns on its strobes in the next cycle. SRAM and PROM strobes then last cfg_waits+1 cycles. An I/O access lasts until the cycle after the edge that samples io_ready_n low. ack, rdata and bus_err follow in the cycle after the last strobe cycle, and ack drops one cycle later. The bench samples every output at the falling edge. It counts strobe cycles until ack appears, so both a missing and an extra cycle show up as a wrong count. It releases io_ready_n at the falling edge of a chosen strobe cycle. It also checks the cycle after ack, the idle cycle between two requests held back to back, and mem_addr several idle cycles after the last access.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 32;
    localparam int EXT_AW    = 23;
    localparam int NUM_BANKS = 4;
    localparam int BANK_LSB  = 21;
    localparam int WAIT_W    = 4;
    localparam int CHK_W     = 7;
    localparam int NUM_HALVES = 2;
    localparam int LANES     = DATA_W / 8;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int HI_W      = ADDR_W - EXT_AW;
    localparam int HALF_BIT  = ADDR_W - 4;

    typedef enum logic [1:0] {
        AREA_NONE,
        AREA_PROM,
        AREA_IO,
        AREA_SRAM
    } area_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM,
        ST_IOWAIT,
        ST_IOLAST,
        ST_DONE
    } state_e;

    typedef struct packed {
        area_e              area;
        logic [BANK_W-1:0]  bank;
        logic               half;
        logic               wr;
        logic               narrow;
        logic               prot;
        logic [LANES-1:0]   be;
        logic [DATA_W-1:0]  wdata;
        logic [CHK_W:0]     cb;
    } acc_t;

    // Area from the address bits above the external address range.
    function automatic area_e area_of(input logic [HI_W-1:0] hi);
        area_e a;
        a = AREA_NONE;
        unique case (hi[HI_W-1 -: 3])
            3'b000: a = AREA_PROM;
            3'b001: a = AREA_IO;
            3'b010: a = (hi[HI_W-4:0] == '0) ? AREA_SRAM : AREA_NONE;
            default: a = AREA_NONE;
        endcase
        return a;
    endfunction

    // Active-high strobe per lane; strobe 0 covers the most significant byte.
    function automatic logic [LANES-1:0] lane_strobes(input logic [LANES-1:0] be,
                                                      input logic narrow);
        logic [LANES-1:0] s;
        for (int i = 0; i < LANES; i++) begin
            s[i] = be[LANES-1-i];
        end
        if (narrow) begin
            s = {{(LANES-1){1'b0}}, be[0]};
        end
        return s;
    endfunction

    // Data as it appears on the external bus.
    function automatic logic [DATA_W-1:0] place_data(input logic [DATA_W-1:0] d,
                                                     input logic narrow);
        return narrow ? {d[7:0], {(DATA_W-8){1'b0}}} : d;
    endfunction

    // Read data as returned to the requester.
    function automatic logic [DATA_W-1:0] gather_data(input logic [DATA_W-1:0] d,
                                                      input logic narrow);
        return narrow ? {{(DATA_W-8){1'b0}}, d[DATA_W-1 -: 8]} : d;
    endfunction

endpackage

// File: rtl/extmem_decode.sv
module extmem_decode
    import extmem_pkg::*;
(
    input  logic [HI_W-1:0]    addr_hi,
    input  logic [BANK_W-1:0]  addr_bank,
    input  logic               write,
    input  logic [LANES-1:0]   be,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CHK_W-1:0]   chk,
    input  logic               prom_narrow,
    input  logic               io_narrow,
    input  logic               protect,
    input  logic               test_bit,
    output acc_t               dec
);

    area_e area;
    logic  narrow;

    always_comb begin
        area   = area_of(addr_hi);
        narrow = ((area == AREA_PROM) && prom_narrow) ||
                 ((area == AREA_IO)   && io_narrow);

        dec        = '0;
        dec.area   = area;
        dec.bank   = addr_bank;
        dec.half   = addr_hi[HI_W-4];
        dec.wr     = write;
        dec.narrow = narrow;
        dec.prot   = protect && !narrow &&
                     ((area == AREA_SRAM) || (area == AREA_PROM));
        dec.be     = be;
        dec.wdata  = wdata;
        dec.cb     = {test_bit, chk};
    end

endmodule

// File: rtl/extmem_seq.sv
module extmem_seq
    import extmem_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  acc_t               dec,
    input  logic [EXT_AW-1:0]  ext_addr,
    input  logic [WAIT_W-1:0]  cfg_waits,
    input  logic               io_ready_n,
    input  logic [DATA_W-1:0]  mem_d_in,
    output state_e             state,
    output acc_t               acc,
    output logic [EXT_AW-1:0]  mem_addr,
    output logic               ack,
    output logic               bus_err,
    output logic [DATA_W-1:0]  rdata
);

    logic [WAIT_W-1:0] cnt;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            acc      <= '0;
            cnt      <= '0;
            mem_addr <= '0;
            err_q    <= 1'b0;
            rdata    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (dec.area == AREA_NONE) begin
                            err_q <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            err_q    <= 1'b0;
                            acc      <= dec;
                            mem_addr <= ext_addr;
                            cnt      <= cfg_waits;
                            state    <= (dec.area == AREA_IO) ? ST_IOWAIT : ST_MEM;
                        end
                    end
                end
                ST_MEM: begin
                    if (cnt == '0) begin
                        rdata <= gather_data(mem_d_in, acc.narrow);
                        state <= ST_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_IOWAIT: begin
                    if (!io_ready_n) begin
                        state <= ST_IOLAST;
                    end
                end
                ST_IOLAST: begin
                    rdata <= gather_data(mem_d_in, acc.narrow);
                    state <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign ack     = (state == ST_DONE);
    assign bus_err = ack && err_q;

endmodule

// File: rtl/extmem_strobe.sv
module extmem_strobe
    import extmem_pkg::*;
(
    input  state_e                  state,
    input  acc_t                    acc,
    output logic [NUM_BANKS-1:0]    sram_cs_n,
    output logic [NUM_BANKS-1:0]    sram_oe_n,
    output logic [LANES-1:0]        wr_n,
    output logic [NUM_HALVES-1:0]   prom_cs_n,
    output logic                    io_cs_n,
    output logic                    io_oe_n,
    output logic                    io_rd,
    output logic                    io_wr_n,
    output logic [DATA_W-1:0]       mem_d_out,
    output logic                    mem_d_oe,
    output logic [CHK_W:0]          cb_out,
    output logic                    cb_oe
);

    logic             active;
    logic             sram_acc;
    logic             prom_acc;
    logic             io_acc;
    logic [LANES-1:0] lane_on;

    always_comb begin
        active   = (state == ST_MEM) || (state == ST_IOWAIT) || (state == ST_IOLAST);
        sram_acc = active && (acc.area == AREA_SRAM);
        prom_acc = active && (acc.area == AREA_PROM);
        io_acc   = active && (acc.area == AREA_IO);
        lane_on  = lane_strobes(acc.be, acc.narrow);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            sram_cs_n[b] = !(sram_acc && (acc.bank == b[BANK_W-1:0]));
            sram_oe_n[b] = !(sram_acc && (acc.bank == b[BANK_W-1:0]) && !acc.wr);
        end
    end

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        always_comb begin
            prom_cs_n[h] = !(prom_acc && (acc.half == h[0]));
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            wr_n[l] = !((sram_acc || prom_acc) && acc.wr && lane_on[l]);
        end
    end

    always_comb begin
        io_cs_n   = !io_acc;
        io_oe_n   = !(io_acc && !acc.wr);
        io_rd     = io_acc && !acc.wr;
        io_wr_n   = !(io_acc && acc.wr);
        mem_d_oe  = active && acc.wr;
        mem_d_out = place_data(acc.wdata, acc.narrow);
        cb_oe     = active && acc.wr && acc.prot;
        cb_out    = acc.cb;
    end

endmodule

// File: rtl/extmem_bus_ctrl.sv
module extmem_bus_ctrl
    import extmem_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [LANES-1:0]        req_be,
    input  logic [CHK_W-1:0]        req_chk,
    output logic                    ack,
    output logic                    bus_err,
    output logic [DATA_W-1:0]       rdata,
    input  logic [WAIT_W-1:0]       cfg_waits,
    input  logic                    cfg_prom_narrow,
    input  logic                    cfg_io_narrow,
    input  logic                    cfg_protect,
    input  logic                    cfg_test_bit,
    output logic [EXT_AW-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_d_out,
    output logic                    mem_d_oe,
    input  logic [DATA_W-1:0]       mem_d_in,
    output logic [CHK_W:0]          cb_out,
    output logic                    cb_oe,
    output logic [NUM_BANKS-1:0]    sram_cs_n,
    output logic [NUM_BANKS-1:0]    sram_oe_n,
    output logic [LANES-1:0]        wr_n,
    output logic [NUM_HALVES-1:0]   prom_cs_n,
    output logic                    io_cs_n,
    output logic                    io_oe_n,
    output logic                    io_rd,
    output logic                    io_wr_n,
    input  logic                    io_ready_n
);

    acc_t   dec;
    acc_t   acc;
    state_e state;

    extmem_decode u_decode (
        .addr_hi     (req_addr[ADDR_W-1:EXT_AW]),
        .addr_bank   (req_addr[BANK_LSB +: BANK_W]),
        .write       (req_write),
        .be          (req_be),
        .wdata       (req_wdata),
        .chk         (req_chk),
        .prom_narrow (cfg_prom_narrow),
        .io_narrow   (cfg_io_narrow),
        .protect     (cfg_protect),
        .test_bit    (cfg_test_bit),
        .dec         (dec)
    );

    extmem_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .dec        (dec),
        .ext_addr   (req_addr[EXT_AW-1:0]),
        .cfg_waits  (cfg_waits),
        .io_ready_n (io_ready_n),
        .mem_d_in   (mem_d_in),
        .state      (state),
        .acc        (acc),
        .mem_addr   (mem_addr),
        .ack        (ack),
        .bus_err    (bus_err),
        .rdata      (rdata)
    );

    extmem_strobe u_strobe (
        .state     (state),
        .acc       (acc),
        .sram_cs_n (sram_cs_n),
        .sram_oe_n (sram_oe_n),
        .wr_n      (wr_n),
        .prom_cs_n (prom_cs_n),
        .io_cs_n   (io_cs_n),
        .io_oe_n   (io_oe_n),
        .io_rd     (io_rd),
        .io_wr_n   (io_wr_n),
        .mem_d_out (mem_d_out),
        .mem_d_oe  (mem_d_oe),
        .cb_out    (cb_out),
        .cb_oe     (cb_oe)
    );

endmodule

// File: rtl/extmem_bus_chk.sv
module extmem_bus_chk
    import extmem_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    ack,
    input logic                    bus_err,
    input logic [EXT_AW-1:0]       mem_addr,
    input logic                    mem_d_oe,
    input logic                    cb_oe,
    input logic [NUM_BANKS-1:0]    sram_cs_n,
    input logic [NUM_BANKS-1:0]    sram_oe_n,
    input logic [LANES-1:0]        wr_n,
    input logic [NUM_HALVES-1:0]   prom_cs_n,
    input logic                    io_cs_n,
    input logic                    io_oe_n,
    input logic                    io_wr_n
);

    logic any_sel;
    assign any_sel = !(&sram_cs_n) || !(&prom_cs_n) || !io_cs_n;

    // R1
    one_group_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~sram_cs_n, ~prom_cs_n, ~io_cs_n}));

    // R2
    sram_oe_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ((~sram_oe_n & sram_cs_n) == '0));

    // R4
    drive_dir_chk: assert property (@(posedge clk) disable iff (rst)
        mem_d_oe |-> ((&sram_oe_n) && io_oe_n && any_sel));

    // R6
    cb_with_data_chk: assert property (@(posedge clk) disable iff (rst)
        cb_oe |-> mem_d_oe);

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R11
    ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (!any_sel && (&wr_n) && io_wr_n && io_oe_n && !mem_d_oe));

    // R12
    err_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ack);

    // R13
    addr_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> any_sel);

endmodule

bind extmem_bus_ctrl extmem_bus_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .bus_err   (bus_err),
    .mem_addr  (mem_addr),
    .mem_d_oe  (mem_d_oe),
    .cb_oe     (cb_oe),
    .sram_cs_n (sram_cs_n),
    .sram_oe_n (sram_oe_n),
    .wr_n      (wr_n),
    .prom_cs_n (prom_cs_n),
    .io_cs_n   (io_cs_n),
    .io_oe_n   (io_oe_n),
    .io_wr_n   (io_wr_n)
);

// File: tb/tb_extmem_bus_ctrl.sv
module tb_extmem_bus_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MEM_RD = 32'hA1B2_C3D4;
    localparam logic [6:0]  CHK_IN = 7'h35;
    localparam logic [7:0]  CB_EXP = 8'hB5;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic [3:0]  req_be;
    logic [6:0]  req_chk;
    logic        ack, bus_err;
    logic [31:0] rdata;
    logic [3:0]  cfg_waits;
    logic        cfg_prom_narrow, cfg_io_narrow, cfg_protect, cfg_test_bit;
    logic [22:0] mem_addr;
    logic [31:0] mem_d_out;
    logic        mem_d_oe;
    logic [31:0] mem_d_in;
    logic [7:0]  cb_out;
    logic        cb_oe;
    logic [3:0]  sram_cs_n, sram_oe_n, wr_n;
    logic [1:0]  prom_cs_n;
    logic        io_cs_n, io_oe_n, io_rd, io_wr_n, io_ready_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    extmem_bus_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_chk(req_chk),
        .ack(ack), .bus_err(bus_err), .rdata(rdata), .cfg_waits(cfg_waits),
        .cfg_prom_narrow(cfg_prom_narrow), .cfg_io_narrow(cfg_io_narrow),
        .cfg_protect(cfg_protect), .cfg_test_bit(cfg_test_bit), .mem_addr(mem_addr),
        .mem_d_out(mem_d_out), .mem_d_oe(mem_d_oe), .mem_d_in(mem_d_in),
        .cb_out(cb_out), .cb_oe(cb_oe), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .wr_n(wr_n), .prom_cs_n(prom_cs_n), .io_cs_n(io_cs_n), .io_oe_n(io_oe_n),
        .io_rd(io_rd), .io_wr_n(io_wr_n), .io_ready_n(io_ready_n)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [3:0]  waits;
        logic [3:0]  io_dly;
        logic        p8;
        logic        i8;
        logic        prot;
        logic [3:0]  x_sram;
        logic [1:0]  x_prom;
        logic        x_io;
        logic [3:0]  x_wrn;
        logic [31:0] x_dout;
        logic        x_cb;
        logic [4:0]  x_strb;
        logic [31:0] x_rdata;
        logic        x_err;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h4000_0010, 32'h1122_3344, 4'hF, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 4'b0001, 2'b00, 1'b0, 4'b0000, 32'h1122_3344, 1'b1, 5'd1,  32'h0,        1'b0},
        '{1'b0, 32'h4040_0020, 32'h0,        4'hF, 4'd3, 4'd0, 1'b0, 1'b0, 1'b1, 4'b0100, 2'b00, 1'b0, 4'b1111, 32'h0,        1'b0, 5'd4,  32'hA1B2_C3D4, 1'b0},
        '{1'b1, 32'h4060_0004, 32'hCAFE_BABE, 4'h1, 4'd2, 4'd0, 1'b0, 1'b0, 1'b0, 4'b1000, 2'b00, 1'b0, 4'b0111, 32'hCAFE_BABE, 1'b0, 5'd3,  32'h0,        1'b0},
        '{1'b1, 32'h4020_0008, 32'hDEAD_BEEF, 4'h8, 4'd1, 4'd0, 1'b0, 1'b0, 1'b1, 4'b0010, 2'b00, 1'b0, 4'b1110, 32'hDEAD_BEEF, 1'b1, 5'd2,  32'h0,        1'b0},
        '{1'b1, 32'h4020_0010, 32'h0BAD_F00D, 4'h6, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 4'b0010, 2'b00, 1'b0, 4'b1001, 32'h0BAD_F00D, 1'b1, 5'd1,  32'h0,        1'b0},
        '{1'b0, 32'h0000_1000, 32'h0,        4'hF, 4'd1, 4'd0, 1'b0, 1'b0, 1'b1, 4'b0000, 2'b01, 1'b0, 4'b1111, 32'h0,        1'b0, 5'd2,  32'hA1B2_C3D4, 1'b0},
        '{1'b0, 32'h1000_0100, 32'h0,        4'hF, 4'd0, 4'd0, 1'b1, 1'b0, 1'b1, 4'b0000, 2'b10, 1'b0, 4'b1111, 32'h0,        1'b0, 5'd1,  32'h0000_00A1, 1'b0},
        '{1'b1, 32'h0000_0200, 32'h0000_00EE, 4'h1, 4'd0, 4'd0, 1'b1, 1'b0, 1'b1, 4'b0000, 2'b01, 1'b0, 4'b1110, 32'hEE00_0000, 1'b0, 5'd1,  32'h0,        1'b0},
        '{1'b0, 32'h2000_0040, 32'h0,        4'hF, 4'd5, 4'd0, 1'b0, 1'b0, 1'b1, 4'b0000, 2'b00, 1'b1, 4'b1111, 32'h0,        1'b0, 5'd2,  32'hA1B2_C3D4, 1'b0},
        '{1'b1, 32'h2000_0044, 32'h55AA_55AA, 4'hF, 4'd0, 4'd3, 1'b0, 1'b0, 1'b1, 4'b0000, 2'b00, 1'b1, 4'b1111, 32'h55AA_55AA, 1'b0, 5'd4,  32'h0,        1'b0},
        '{1'b0, 32'h2000_0048, 32'h0,        4'hF, 4'd0, 4'd2, 1'b0, 1'b1, 1'b1, 4'b0000, 2'b00, 1'b1, 4'b1111, 32'h0,        1'b0, 5'd3,  32'h0000_00A1, 1'b0},
        '{1'b0, 32'h8000_0000, 32'h0,        4'hF, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 4'b0000, 2'b00, 1'b0, 4'b1111, 32'h0,        1'b0, 5'd0,  32'h0,        1'b1},
        '{1'b1, 32'h4080_0000, 32'h1234_5678, 4'hF, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 4'b0000, 2'b00, 1'b0, 4'b1111, 32'h0,        1'b0, 5'd0,  32'h0,        1'b1},
        '{1'b1, 32'h1800_0000, 32'h1357_9BDF, 4'hF, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 4'b0000, 2'b10, 1'b0, 4'b0000, 32'h1357_9BDF, 1'b1, 5'd1,  32'h0,        1'b0},
        '{1'b0, 32'h407F_FFFC, 32'h0,        4'hF, 4'd15, 4'd0, 1'b0, 1'b0, 1'b1, 4'b1000, 2'b00, 1'b0, 4'b1111, 32'h0,       1'b0, 5'd16, 32'hA1B2_C3D4, 1'b0}
    };

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit any_strobe();
        return (sram_cs_n != 4'hF) || (prom_cs_n != 2'b11) || !io_cs_n;
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        int          strb = 0;
        int          guard = 0;
        bit          got = 1'b0;
        logic [3:0]  sr = '0, soe = '0, wrl = '0;
        logic [1:0]  pr = '0;
        logic        io = 1'b0, iord = 1'b0, iowr = 1'b0, oe_seen = 1'b0, cb_seen = 1'b0;
        logic        quiet_at_ack = 1'b1;
        logic [31:0] dout = '0;
        logic [7:0]  cbv = '0;
        logic [22:0] a_first = '0;
        logic [31:0] rd = '0;
        logic        er = 1'b0;
        cfg_waits       = v.waits;
        cfg_prom_narrow = v.p8;
        cfg_io_narrow   = v.i8;
        cfg_protect     = v.prot;
        req_write       = v.wr;
        req_addr        = v.addr;
        req_wdata       = v.wdata;
        req_be          = v.be;
        io_ready_n      = (v.io_dly == 0) ? 1'b0 : 1'b1;
        req_valid       = 1'b1;
        while (!got && guard < 100) begin
            @(negedge clk);
            guard++;
            if (ack) begin
                got = 1'b1;
                rd  = rdata;
                er  = bus_err;
                quiet_at_ack = !any_strobe() && (wr_n == 4'hF) && io_wr_n && !mem_d_oe;
                req_valid = 1'b0;
            end else if (any_strobe()) begin
                strb++;
                if (strb == 1) a_first = mem_addr;
                sr   |= ~sram_cs_n;
                soe  |= ~sram_oe_n;
                pr   |= ~prom_cs_n;
                io   |= ~io_cs_n;
                wrl  |= ~wr_n;
                iord |= io_rd & ~io_oe_n;
                iowr |= ~io_wr_n;
                if (mem_d_oe) begin oe_seen = 1'b1; dout = mem_d_out; end
                if (cb_oe) begin cb_seen = 1'b1; cbv = cb_out; end
                if (v.io_dly != 0 && strb >= int'(v.io_dly)) io_ready_n = 1'b0;
            end
        end
        req_valid  = 1'b0;
        io_ready_n = 1'b1;
        $display("vector %0d: %0d strobe cycles", idx, strb);
        chk("R10 ack seen", {31'b0, got}, 32'd1);
        // R1 R2 selects, R7 I/O select
        chk("R1 R2 sram selects", {28'b0, sr}, {28'b0, v.x_sram});
        chk("R1 prom selects", {30'b0, pr}, {30'b0, v.x_prom});
        chk("R7 io select", {31'b0, io}, {31'b0, v.x_io});
        chk("R2 sram oe on reads", {31'b0, (soe != 0)}, {31'b0, (v.x_sram != 0) && !v.wr});
        chk("R3 byte strobes", {28'b0, ~wrl}, {28'b0, v.x_wrn});
        chk("R4 data drive", {31'b0, oe_seen}, {31'b0, v.wr && !v.x_err});
        if (v.wr && !v.x_err) chk("R4 R5 data value", dout, v.x_dout);
        chk("R6 checkbit drive", {31'b0, cb_seen}, {31'b0, v.x_cb});
        if (v.x_cb) chk("R6 checkbit value", {24'b0, cbv}, {24'b0, CB_EXP});
        chk("R7 io read", {31'b0, iord}, {31'b0, v.x_io && !v.wr});
        chk("R7 io write", {31'b0, iowr}, {31'b0, v.x_io && v.wr});
        chk("R8 R9 strobe cycles", strb, {27'b0, v.x_strb});
        chk("R12 bus error", {31'b0, er}, {31'b0, v.x_err});
        chk("R11 quiet at ack", {31'b0, quiet_at_ack}, 32'd1);
        if (!v.x_err) chk("R13 address", {9'b0, a_first}, {9'b0, v.addr[22:0]});
        if (!v.wr && !v.x_err) chk("R10 R5 read data", rd, v.x_rdata);
        @(negedge clk);
        chk("R10 ack one cycle", {31'b0, ack}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
        req_chk = CHK_IN; cfg_waits = '0; cfg_prom_narrow = 1'b0; cfg_io_narrow = 1'b0;
        cfg_protect = 1'b0; cfg_test_bit = 1'b1; mem_d_in = MEM_RD; io_ready_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R14 reset state
        chk("R14 selects idle", {24'b0, sram_cs_n, prom_cs_n, io_cs_n, io_oe_n}, {24'b0, 4'hF, 2'b11, 1'b1, 1'b1});
        chk("R14 strobes idle", {26'b0, wr_n, io_wr_n, io_rd}, {26'b0, 4'hF, 1'b1, 1'b0});
        chk("R14 drive and ack", {29'b0, mem_d_oe, cb_oe, ack}, 32'd0);
        chk("R14 address zero", {9'b0, mem_addr}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
        end

        // R13 address held while idle
        repeat (3) @(negedge clk);
        chk("R13 address held", {9'b0, mem_addr}, 32'h007F_FFFC);
        // R12 unmapped access leaves the address alone
        run_vec(VECS[11], 11);
        chk("R12 address unchanged", {9'b0, mem_addr}, 32'h007F_FFFC);

        // R11 back-to-back requests are separated by an idle cycle
        cfg_waits = 4'd0; cfg_protect = 1'b0; req_write = 1'b0;
        req_addr = 32'h4000_0100; req_be = 4'hF; req_valid = 1'b1;
        @(negedge clk);
        chk("R11 first access active", {31'b0, any_strobe()}, 32'd1);
        @(negedge clk);
        chk("R11 first ack", {31'b0, ack}, 32'd1);
        @(negedge clk);
        chk("R11 idle gap", {30'b0, any_strobe(), ack}, 32'd0);
        @(negedge clk);
        chk("R11 second access active", {31'b0, any_strobe()}, 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 second ack", {31'b0, ack}, 32'd1);
        @(negedge clk);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule